// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the control unit of a single-cycle 32-bit load/store processor. It is purely combinational. From the 6-bit opcode field (instruction bits 31:26) it derives every select and write strobe that the merged datapath needs. It also takes a flag that is high when the first register operand is zero, and a pending asynchronous interrupt request. The datapath, the ALU and both memories are outside this block. The decoder only tells them what to do in the current cycle.

Register-operate instructions (opcode pattern 10xxxx) and literal-operate instructions (pattern 11xxxx) carry the ALU operation in the low four opcode bits. The memory and control-transfer instructions sit in the 01xxxx group:

| Instruction | Opcode |
|---|---|
| load | 011000 |
| store | 011001 |
| jump | 011011 |
| branch-if-zero | 011100 |
| branch-if-nonzero | 011101 |
| PC-relative load | 011111 |

Every other opcode is illegal. An illegal opcode turns the cycle into a forced call through the fault vector. A pending interrupt does the same through the interrupt vector. In both cases the return address goes into the exception-link register, and the instruction has no other effect.

Top module: `ctrl_decoder`

## Requirements
- R1: For a register-operate opcode 10nnnn with a legal ALU nibble nnnn:
  - aluFn equals nnnn, with the codes ADD 0, SUB 1, MUL 2, DIV 3, CMPEQ 4, CMPLT 5, CMPLE 6, AND 8, OR 9, XOR 10, SHL 12, SHR 13, SRA 14.
  - bSel is 0, so the second register is the operand.
  - wdSel is 1 (ALU), waSel is 0 (Rc), wrRf is 1 and pcSel is 0 (PC+4).
- R2: A literal-operate opcode 11nnnn behaves as in R1, except that bSel is 1 (sign-extended literal).
- R3: ALU nibbles 7, 11 and 15 are illegal in both operate groups. Nibble 2 (MUL) is legal only when HAS_MUL is set, and nibble 3 (DIV) only when HAS_DIV is set. Both parameters default to 0.
- R4: A load (011000) drives bSel 1, aluFn ADD, wdSel 2 (memory read data) and wrRf 1.
- R5: A store (011001) drives ra2Sel 1 (second read port addresses Rc), bSel 1, aluFn ADD, wrMem 1 and wrRf 0.
- R6: A jump (011011) drives pcSel 2 (register target), wdSel 0 (PC+4) and wrRf 1.
- R7: Branch-if-zero (011100) and branch-if-nonzero (011101) both drive wdSel 0 and wrRf 1.
  - Branch-if-zero drives pcSel 1 (branch target) when raZero is 1, and pcSel 0 otherwise.
  - Branch-if-nonzero does the opposite.
- R8: A PC-relative load (011111) drives aSel 1 (PC-relative target into ALU operand A), aluFn 15 (pass A), wdSel 2 and wrRf 1.
- R9: With no interrupt pending, any illegal opcode drives pcSel 3 (fault vector), waSel 1 (exception-link register), wdSel 0, wrRf 1 and wrMem 0.
- R10: When irq is 1, the outputs are pcSel 4 (interrupt vector), waSel 1, wdSel 0, wrRf 1 and wrMem 0, whatever the opcode and raZero are.
- R11: wrMem is 1 only for a store with irq low. Every exception forces it low.
- R12: waSel is 1 exactly when an exception is taken. Otherwise it is 0.
- R13: Selects that an instruction does not use stay at their defaults:
  - ra2Sel 0, aSel 0, bSel 0 and aluFn ADD for jumps, branches and exceptions.
  - wdSel 1 for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31:26 |
| raZero | input | 1 | High when the first register operand is zero |
| irq | input | 1 | Pending asynchronous interrupt |
| pcSel | output | 3 | Next-PC select: 0 PC+4, 1 branch, 2 jump, 3 fault vector, 4 interrupt vector |
| ra2Sel | output | 1 | Second read address: 0 Rb, 1 Rc |
| aSel | output | 1 | ALU operand A: 0 register, 1 PC-relative target |
| bSel | output | 1 | ALU operand B: 0 register, 1 literal |
| aluFn | output | 4 | ALU function code |
| wdSel | output | 2 | Register write data: 0 PC+4, 1 ALU, 2 memory |
| waSel | output | 1 | Register write address: 0 Rc, 1 exception-link register |
| wrRf | output | 1 | Register file write enable |
| wrMem | output | 1 | Data memory write enable |

## Verification
The embedded checks assume that opcode, raZero and irq are settled, two-state values whenever the outputs are looked at. They also assume that raZero matters only to the two branch opcodes. The stimulus changes all inputs together one time unit after a rising edge, and it never leaves an input at X. Every opcode is applied with every combination of raZero and irq, so each check sees both its triggering and non-triggering cases. The outputs are compared half a cycle later.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  localparam int OPC_W  = 6;
  localparam int NIB_W  = 4;
  localparam int NIB_N  = 1 << NIB_W;

  localparam logic [OPC_W-1:0] OPC_LD   = 6'b011000;
  localparam logic [OPC_W-1:0] OPC_ST   = 6'b011001;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'b011011;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b011100;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'b011101;
  localparam logic [OPC_W-1:0] OPC_LDR  = 6'b011111;

  typedef enum logic [NIB_W-1:0] {
    ALU_ADD   = 4'h0,
    ALU_SUB   = 4'h1,
    ALU_MUL   = 4'h2,
    ALU_DIV   = 4'h3,
    ALU_CMPEQ = 4'h4,
    ALU_CMPLT = 4'h5,
    ALU_CMPLE = 4'h6,
    ALU_AND   = 4'h8,
    ALU_OR    = 4'h9,
    ALU_XOR   = 4'hA,
    ALU_SHL   = 4'hC,
    ALU_SHR   = 4'hD,
    ALU_SRA   = 4'hE,
    ALU_PASSA = 4'hF
  } aluFn_e;

  typedef enum logic [2:0] {
    PC_NEXT   = 3'd0,
    PC_BRANCH = 3'd1,
    PC_JUMP   = 3'd2,
    PC_ILLOP  = 3'd3,
    PC_IRQ    = 3'd4
  } pcSel_e;

  typedef enum logic [1:0] {
    WD_LINK = 2'd0,
    WD_ALU  = 2'd1,
    WD_MEM  = 2'd2
  } wdSel_e;

  typedef enum logic [3:0] {
    CLS_OPR,
    CLS_OPL,
    CLS_LOAD,
    CLS_STORE,
    CLS_JUMP,
    CLS_BRZ,
    CLS_BRNZ,
    CLS_LOADREL,
    CLS_ILLEGAL
  } instClass_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   ra2Sel;
    logic   aSel;
    logic   bSel;
    aluFn_e aluFn;
    wdSel_e wdSel;
    logic   waSel;
    logic   wrRf;
    logic   wrMem;
  } strobes_t;

  // One bit per ALU nibble: set when that operate encoding is implemented.
  function automatic logic [NIB_N-1:0] aluLegalMask(input bit hasMul, input bit hasDiv);
    logic [NIB_N-1:0] m;
    m = '0;
    m[ALU_ADD]   = 1'b1;
    m[ALU_SUB]   = 1'b1;
    m[ALU_MUL]   = hasMul;
    m[ALU_DIV]   = hasDiv;
    m[ALU_CMPEQ] = 1'b1;
    m[ALU_CMPLT] = 1'b1;
    m[ALU_CMPLE] = 1'b1;
    m[ALU_AND]   = 1'b1;
    m[ALU_OR]    = 1'b1;
    m[ALU_XOR]   = 1'b1;
    m[ALU_SHL]   = 1'b1;
    m[ALU_SHR]   = 1'b1;
    m[ALU_SRA]   = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ctrl_opclass.sv
module ctrl_opclass
  import ctrl_pkg::*;
#(
  parameter bit HAS_MUL = 1'b0,
  parameter bit HAS_DIV = 1'b0
) (
  input  logic [OPC_W-1:0] opcode,
  output instClass_e       cls,
  output aluFn_e           aluOp
);

  localparam logic [NIB_N-1:0] LEGAL = aluLegalMask(HAS_MUL, HAS_DIV);

  logic [NIB_W-1:0] nib;
  logic             nibOk;

  assign nib   = opcode[NIB_W-1:0];
  assign nibOk = LEGAL[nib];

  always_comb begin
    aluOp = nibOk ? aluFn_e'(nib) : ALU_ADD;
    cls   = CLS_ILLEGAL;
    case (opcode[OPC_W-1 -: 2])
      2'b10: cls = nibOk ? CLS_OPR : CLS_ILLEGAL;
      2'b11: cls = nibOk ? CLS_OPL : CLS_ILLEGAL;
      2'b01: begin
        case (opcode)
          OPC_LD:  cls = CLS_LOAD;
          OPC_ST:  cls = CLS_STORE;
          OPC_JMP: cls = CLS_JUMP;
          OPC_BEQ: cls = CLS_BRZ;
          OPC_BNE: cls = CLS_BRNZ;
          OPC_LDR: cls = CLS_LOADREL;
          default: cls = CLS_ILLEGAL;
        endcase
      end
      default: cls = CLS_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/ctrl_strobes.sv
module ctrl_strobes
  import ctrl_pkg::*;
(
  input  instClass_e cls,
  input  aluFn_e     aluOp,
  input  logic       raZero,
  input  logic       irq,
  output strobes_t   strb
);

  always_comb begin
    strb.pcSel  = PC_NEXT;
    strb.ra2Sel = 1'b0;
    strb.aSel   = 1'b0;
    strb.bSel   = 1'b0;
    strb.aluFn  = ALU_ADD;
    strb.wdSel  = WD_ALU;
    strb.waSel  = 1'b0;
    strb.wrRf   = 1'b1;
    strb.wrMem  = 1'b0;

    if (irq) begin
      strb.pcSel = PC_IRQ;
      strb.wdSel = WD_LINK;
      strb.waSel = 1'b1;
    end else begin
      case (cls)
        CLS_OPR: strb.aluFn = aluOp;
        CLS_OPL: begin
          strb.aluFn = aluOp;
          strb.bSel  = 1'b1;
        end
        CLS_LOAD: begin
          strb.bSel  = 1'b1;
          strb.wdSel = WD_MEM;
        end
        CLS_STORE: begin
          strb.ra2Sel = 1'b1;
          strb.bSel   = 1'b1;
          strb.wrRf   = 1'b0;
          strb.wrMem  = 1'b1;
        end
        CLS_JUMP: begin
          strb.pcSel = PC_JUMP;
          strb.wdSel = WD_LINK;
        end
        CLS_BRZ: begin
          strb.pcSel = raZero ? PC_BRANCH : PC_NEXT;
          strb.wdSel = WD_LINK;
        end
        CLS_BRNZ: begin
          strb.pcSel = raZero ? PC_NEXT : PC_BRANCH;
          strb.wdSel = WD_LINK;
        end
        CLS_LOADREL: begin
          strb.aSel  = 1'b1;
          strb.aluFn = ALU_PASSA;
          strb.wdSel = WD_MEM;
        end
        default: begin
          strb.pcSel = PC_ILLOP;
          strb.wdSel = WD_LINK;
          strb.waSel = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pkg::*;
#(
  parameter bit HAS_MUL = 1'b0,
  parameter bit HAS_DIV = 1'b0
) (
  input  logic [5:0] opcode,
  input  logic       raZero,
  input  logic       irq,
  output logic [2:0] pcSel,
  output logic       ra2Sel,
  output logic       aSel,
  output logic       bSel,
  output logic [3:0] aluFn,
  output logic [1:0] wdSel,
  output logic       waSel,
  output logic       wrRf,
  output logic       wrMem
);

  instClass_e cls;
  aluFn_e     aluOp;
  strobes_t   strb;

  ctrl_opclass #(
    .HAS_MUL(HAS_MUL),
    .HAS_DIV(HAS_DIV)
  ) u_opclass (
    .opcode(opcode),
    .cls   (cls),
    .aluOp (aluOp)
  );

  ctrl_strobes u_strobes (
    .cls   (cls),
    .aluOp (aluOp),
    .raZero(raZero),
    .irq   (irq),
    .strb  (strb)
  );

  assign pcSel  = strb.pcSel;
  assign ra2Sel = strb.ra2Sel;
  assign aSel   = strb.aSel;
  assign bSel   = strb.bSel;
  assign aluFn  = strb.aluFn;
  assign wdSel  = strb.wdSel;
  assign waSel  = strb.waSel;
  assign wrRf   = strb.wrRf;
  assign wrMem  = strb.wrMem;

  // Port-level consistency checks on the settled outputs.
  always_comb begin
    if (wrMem) begin
      a_r11_mem_write_only_store: assert (opcode == OPC_ST && !irq)
        else $error("memory write outside a plain store");
      a_r5_store_no_rf_write: assert (!wrRf)
        else $error("store also writes the register file");
    end
    if (irq) begin
      a_r10_irq_vector: assert (pcSel == 3'd4 && waSel && wrRf && wdSel == 2'd0)
        else $error("interrupt did not force the vector call");
    end
    if (pcSel == 3'd3) begin
      a_r9_fault_links_xp: assert (!irq && waSel && wdSel == 2'd0 && !wrMem)
        else $error("fault vector without link write");
    end
    if (pcSel == 3'd1) begin
      a_r7_branch_condition: assert ((opcode == OPC_BEQ && raZero) || (opcode == OPC_BNE && !raZero))
        else $error("branch taken on wrong condition");
    end
    if (!waSel) begin
      a_r12_rc_outside_exceptions: assert (pcSel < 3'd3)
        else $error("exception vector with write address Rc");
    end
  end

endmodule

// File: tb/ctrl_decoder_tb.sv
module ctrl_decoder_tb;

  localparam bit HAS_MUL = 1'b0;
  localparam bit HAS_DIV = 1'b0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [5:0] opcode = '0;
  logic       raZero = 1'b0;
  logic       irq    = 1'b0;
  logic [2:0] pcSel;
  logic       ra2Sel, aSel, bSel;
  logic [3:0] aluFn;
  logic [1:0] wdSel;
  logic       waSel, wrRf, wrMem;

  ctrl_decoder #(.HAS_MUL(HAS_MUL), .HAS_DIV(HAS_DIV)) u_dut (
    .opcode(opcode), .raZero(raZero), .irq(irq),
    .pcSel(pcSel), .ra2Sel(ra2Sel), .aSel(aSel), .bSel(bSel),
    .aluFn(aluFn), .wdSel(wdSel), .waSel(waSel), .wrRf(wrRf), .wrMem(wrMem)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [5:0]  opc;
    logic        z;
    logic        i;
    logic [14:0] exp;
    string       tag;
  } item_t;

  item_t q[$];

  function automatic logic [14:0] gotVec();
    return {pcSel, ra2Sel, aSel, bSel, aluFn, wdSel, waSel, wrRf, wrMem};
  endfunction

  function automatic bit legalNib(input logic [3:0] n);
    case (n)
      4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14: return 1'b1;
      4'd2: return HAS_MUL;
      4'd3: return HAS_DIV;
      default: return 1'b0;
    endcase
  endfunction

  // Expected strobes from the requirements.
  function automatic logic [14:0] model(input logic [5:0] o, input logic z, input logic i);
    logic [2:0] pc = 3'd0;
    logic       r2 = 1'b0, a = 1'b0, b = 1'b0;
    logic [3:0] fn = 4'd0;
    logic [1:0] wd = 2'd1;
    logic       wa = 1'b0, rf = 1'b1, wm = 1'b0;
    bit         ill = 1'b0;
    if (i) begin
      pc = 3'd4; wd = 2'd0; wa = 1'b1;
    end else begin
      if (o[5]) begin
        if (legalNib(o[3:0])) begin fn = o[3:0]; b = o[4]; end
        else ill = 1'b1;
      end else begin
        case (o)
          6'b011000: begin b = 1'b1; wd = 2'd2; end
          6'b011001: begin r2 = 1'b1; b = 1'b1; rf = 1'b0; wm = 1'b1; end
          6'b011011: begin pc = 3'd2; wd = 2'd0; end
          6'b011100: begin pc = z ? 3'd1 : 3'd0; wd = 2'd0; end
          6'b011101: begin pc = z ? 3'd0 : 3'd1; wd = 2'd0; end
          6'b011111: begin a = 1'b1; fn = 4'd15; wd = 2'd2; end
          default: ill = 1'b1;
        endcase
      end
      if (ill) begin pc = 3'd3; wd = 2'd0; wa = 1'b1; end
    end
    return {pc, r2, a, b, fn, wd, wa, rf, wm};
  endfunction

  function automatic string tagFor(input logic [5:0] o, input logic i);
    if (i) return "R10";
    if (o[5]) return legalNib(o[3:0]) ? (o[4] ? "R2" : "R1") : "R3";
    case (o)
      6'b011000: return "R4";
      6'b011001: return "R5";
      6'b011011: return "R6";
      6'b011100, 6'b011101: return "R7";
      6'b011111: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [5:0] o, input logic [14:0] got, input logic [14:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s opcode=%b raZero=%b irq=%b actual=%h expected=%h",
               tag, o, raZero, irq, got, exp);
    end
  endtask

  task automatic drive(input logic [5:0] o, input logic z, input logic i);
    item_t it;
    @(posedge clk);
    #1;
    opcode = o; raZero = z; irq = i;
    it.opc = o; it.z = z; it.i = i;
    it.exp = model(o, z, i);
    it.tag = tagFor(o, i);
    q.push_back(it);
  endtask

  // Monitor: pops one expected item per cycle and compares away from the edge.
  always @(negedge clk) begin
    item_t it;
    logic [14:0] got;
    if (!rst && q.size() > 0) begin
      it  = q.pop_front();
      got = gotVec();
      check(it.tag, it.opc, got, it.exp);
      check("R11", it.opc, {14'd0, got[0]}, {14'd0, it.exp[0]});
      check("R12", it.opc, {14'd0, got[2]}, {14'd0, it.exp[2]});
      if (it.exp[11:9] == 3'b000)
        check("R13", it.opc, {12'd0, got[11:9]}, {12'd0, it.exp[11:9]});
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle inputs during reset: opcode 000000 is illegal (R9).
    check("R9", opcode, gotVec(), model(6'd0, 1'b0, 1'b0));
    @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 2; i++)
      for (int z = 0; z < 2; z++)
        for (int o = 0; o < 64; o++)
          drive(6'(o), z[0], i[0]);
    // Interrupt landing on a store, and branches around it.
    drive(6'b011001, 1'b0, 1'b1);
    drive(6'b011100, 1'b1, 1'b0);
    drive(6'b011100, 1'b1, 1'b1);
    drive(6'b011101, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule